// File: doc/BRIEF.md
# Self-Timed Switch Shutdown Sequencer

This block turns a long low pulse on an active-low external request line into a timed shutdown of a battery pack's charge and discharge switches. A host controller that wants to power-cycle itself drives the line low. Once the line has stayed low long enough, and provided the protection controller reports normal operation, the block raises a force-off signal for a fixed interval. The surrounding logic ANDs the inverse of that signal into both switch enables.

When the interval ends, the block drops the force-off signal by itself. It does not wait for the request line to go high again. It then stays unarmed until the line has returned high, so a line that is stuck low cannot cause the switches to cycle over and over. The request line is resynchronised with a flop chain before it is qualified. Both time windows are parameters counted in clock cycles.

Top module: `pack_kill_seq`

## Requirements
- R1: After reset, `force_off_o` and `busy_o` are both 0.
- R2: While `kill_req_n_i` stays high (1 = no request), `force_off_o` stays 0 whatever `normal_mode_i` does.
- R3: When `kill_req_n_i` goes low while `normal_mode_i` is 1 and stays low for QUAL_CYCLES clocks, `force_off_o` goes to 1 exactly QUAL_CYCLES + SYNC_STAGES clock edges after the first edge that samples the low level.
- R4: A low pulse shorter than QUAL_CYCLES clocks is ignored. Any high level clears the qualification count, so short pulses separated by a high level never add up.
- R5: A request counts only while `normal_mode_i` is 1. A cycle with `normal_mode_i` at 0 clears the qualification count, and counting restarts once normal mode returns.
- R6: `force_off_o` stays 1 for exactly RELEASE_CYCLES clocks and then returns to 0, even if `kill_req_n_i` is still low.
- R7: `busy_o` is 1 for the whole force-off interval. After release, it stays 1 until the synchronised request line is high again.
- R8: After release with the line still low, no new force-off occurs. Once the line has been high, a new qualified low pulse triggers again.
- R9: During the force-off interval, changes on `kill_req_n_i` or `normal_mode_i` do not change its length.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low block reset |
| kill_req_n_i | input | 1 | Asynchronous active-low shutdown request line |
| normal_mode_i | input | 1 | 1 when the protection controller is in normal mode |
| force_off_o | output | 1 | 1 forces both pack switches off |
| busy_o | output | 1 | 1 while a shutdown is running or the block waits for the line to go high |

## Verification
The bench aims at the edges of the qualification window. A pulse one clock short must be ignored and a pulse of exactly the window must trigger. A design that counted one cycle off, or let separate short pulses add up, would trip on glitches or miss a genuine request.

It also holds the line low after release. A design that re-armed at once would cycle the switches endlessly from a stuck line. Dropping normal mode during qualification, and toggling the inputs during the hold, expose a sequencer that ignores the mode gate or lets the input cut the off time short.

// File: rtl/pack_kill_pkg.sv
package pack_kill_pkg;
    typedef enum logic [1:0] {
        SEQ_ARMED     = 2'd0,
        SEQ_HOLD      = 2'd1,
        SEQ_WAIT_HIGH = 2'd2
    } seq_state_e;

    typedef struct packed {
        seq_state_e state;
        logic       force_off;
        logic       busy;
    } seq_regs_t;
endpackage

// File: rtl/pack_kill_sync.sv
module pack_kill_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_i,
    output logic sync_o
);
    logic [STAGES-1:0] chain_d, chain_q;

    generate
        if (STAGES == 1) begin : g_single
            always_comb chain_d = async_i;
        end else begin : g_multi
            always_comb chain_d = {chain_q[STAGES-2:0], async_i};
        end
    endgenerate

    // Idle level of the active-low line is high.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '1;
        else        chain_q <= chain_d;
    end

    assign sync_o = chain_q[STAGES-1];
endmodule

// File: rtl/pack_kill_timer.sv
module pack_kill_timer #(
    parameter int LIMIT = 20
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run_i,
    output logic done_o
);
    localparam int W = $clog2(LIMIT + 1);
    localparam logic [W-1:0] LAST = W'(LIMIT - 1);

    logic [W-1:0] cnt_d, cnt_q;

    assign done_o = run_i && (cnt_q == LAST);

    always_comb begin
        cnt_d = cnt_q;
        if (!run_i || done_o) cnt_d = '0;
        else                  cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    // The count never passes the last step of its window (R4, R6).
    assert_cnt_in_range_R6: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= LAST);
    // An idle timer restarts from zero (R4).
    assert_clear_on_idle_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !run_i |=> cnt_q == '0);
endmodule

// File: rtl/pack_kill_seq.sv
module pack_kill_seq
    import pack_kill_pkg::*;
#(
    parameter int SYNC_STAGES    = 2,
    parameter int QUAL_CYCLES    = 20,
    parameter int RELEASE_CYCLES = 1000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic kill_req_n_i,
    input  logic normal_mode_i,
    output logic force_off_o,
    output logic busy_o
);
    logic      req_n_sync;
    logic      req_low;
    logic      qual_run, qual_done;
    logic      hold_run, hold_done;
    seq_regs_t r_d, r_q;

    pack_kill_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .async_i(kill_req_n_i), .sync_o(req_n_sync));

    assign req_low  = !req_n_sync;
    assign qual_run = (r_q.state == SEQ_ARMED) && req_low && normal_mode_i;
    assign hold_run = (r_q.state == SEQ_HOLD);

    pack_kill_timer #(.LIMIT(QUAL_CYCLES)) u_qual (
        .clk(clk), .rst_n(rst_n), .run_i(qual_run), .done_o(qual_done));

    pack_kill_timer #(.LIMIT(RELEASE_CYCLES)) u_hold (
        .clk(clk), .rst_n(rst_n), .run_i(hold_run), .done_o(hold_done));

    always_comb begin
        r_d = r_q;
        unique case (r_q.state)
            SEQ_ARMED:     if (qual_done) r_d.state = SEQ_HOLD;
            SEQ_HOLD:      if (hold_done) r_d.state = req_low ? SEQ_WAIT_HIGH : SEQ_ARMED;
            SEQ_WAIT_HIGH: if (!req_low)  r_d.state = SEQ_ARMED;
            default:                      r_d.state = SEQ_ARMED;
        endcase
        r_d.force_off = (r_d.state == SEQ_HOLD);
        r_d.busy      = (r_d.state != SEQ_ARMED);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '{state: SEQ_ARMED, force_off: 1'b0, busy: 1'b0};
        else        r_q <= r_d;
    end

    assign force_off_o = r_q.force_off;
    assign busy_o      = r_q.busy;

    // Checker state: length of the current force-off run.
    int unsigned off_len_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)           off_len_q <= 0;
        else if (force_off_o) off_len_q <= off_len_q + 1;
        else                  off_len_q <= 0;
    end

    assert_entry_needs_normal_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(force_off_o) |-> $past(normal_mode_i));
    assert_entry_needs_low_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(force_off_o) |-> $past(req_low));
    assert_exact_off_width_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(force_off_o) |-> off_len_q == RELEASE_CYCLES);
    assert_off_not_too_long_R9: assert property (@(posedge clk) disable iff (!rst_n)
        off_len_q <= RELEASE_CYCLES);
    assert_busy_covers_off_R7: assert property (@(posedge clk) disable iff (!rst_n)
        force_off_o |-> busy_o);
    assert_no_retrigger_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.state == SEQ_WAIT_HIGH) |=> !force_off_o);
endmodule

// File: tb/pack_kill_seq_tb.sv
module pack_kill_seq_tb;
    localparam int SYNC = 2;
    localparam int QUAL = 20;
    localparam int REL  = 100;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req_n = 1'b1;
    logic normal = 1'b1;
    logic force_off, busy;
    int total = 0;
    int bad = 0;
    int cycles = 0;

    always #5 clk = ~clk;

    pack_kill_seq #(.SYNC_STAGES(SYNC), .QUAL_CYCLES(QUAL), .RELEASE_CYCLES(REL)) u_dut (
        .clk(clk), .rst_n(rst_n), .kill_req_n_i(req_n), .normal_mode_i(normal),
        .force_off_o(force_off), .busy_o(busy));

    task automatic chk(input string tag, input logic act, input logic exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0b expected=%0b", tag, act, exp);
        end
    endtask

    task automatic chk_int(input string tag, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Advance n clocks; returns at the falling edge after the last rising edge.
    task automatic step(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    // Count clocks force_off stays high, starting at the current sample.
    task automatic measure_off(output int len);
        len = 0;
        while (force_off === 1'b1 && len < REL + 50) begin
            len++;
            step(1);
        end
    endtask

    task automatic t_reset;
        chk("R1 force_off after reset", force_off, 1'b0);
        chk("R1 busy after reset", busy, 1'b0);
    endtask

    task automatic t_idle_high;
        logic seen = 1'b0;
        req_n = 1'b1;
        for (int i = 0; i < 60; i++) begin
            normal = i[2];
            step(1);
            if (force_off) seen = 1'b1;
        end
        normal = 1'b1;
        chk("R2 high line never forces off", seen, 1'b0);
    endtask

    task automatic t_short_pulses;
        logic seen = 1'b0;
        for (int p = 0; p < 3; p++) begin
            req_n = 1'b0; step(QUAL - 1);
            req_n = 1'b1; step(1);
        end
        for (int i = 0; i < QUAL + 10; i++) begin
            step(1);
            if (force_off) seen = 1'b1;
        end
        chk("R4 short pulses ignored", seen, 1'b0);
    endtask

    task automatic t_exact_and_release;
        int len;
        req_n = 1'b0; step(QUAL);
        req_n = 1'b1;
        step(SYNC - 1);
        chk("R3 not yet at qual+sync-1", force_off, 1'b0);
        step(1);
        chk("R3 forced off at qual+sync", force_off, 1'b1);
        chk("R7 busy during off", busy, 1'b1);
        measure_off(len);
        chk_int("R6 off width", len, REL);
        chk("R7 busy clear after release with line high", busy, 1'b0);
    endtask

    task automatic t_mode_gate;
        logic seen = 1'b0;
        normal = 1'b0; req_n = 1'b0;
        for (int i = 0; i < 3 * QUAL; i++) begin
            step(1);
            if (force_off) seen = 1'b1;
        end
        chk("R5 no entry outside normal mode", seen, 1'b0);
        normal = 1'b1;
        step(QUAL - 1);
        chk("R5 count restarts after mode returns", force_off, 1'b0);
        step(1);
        chk("R5 entry after full window in normal mode", force_off, 1'b1);
    endtask

    task automatic t_stuck_low;
        int len;
        // Continues from t_mode_gate: line still low, off interval running.
        for (int i = 0; i < 10; i++) begin normal = i[0]; step(1); end
        normal = 1'b1;
        measure_off(len);
        chk_int("R9 off width unaffected by mode toggling", len + 10, REL);
        chk("R6 release while line still low", force_off, 1'b0);
        chk("R7 busy held while line still low", busy, 1'b1);
        begin
            logic seen = 1'b0;
            for (int i = 0; i < 3 * QUAL; i++) begin
                step(1);
                if (force_off) seen = 1'b1;
            end
            chk("R8 no retrigger on stuck line", seen, 1'b0);
        end
        req_n = 1'b1; step(SYNC + 1);
        chk("R7 busy clears once line high", busy, 1'b0);
        req_n = 1'b0; step(QUAL + SYNC);
        chk("R8 rearmed after line high", force_off, 1'b1);
    endtask

    task automatic t_hold_toggle;
        int len;
        // Off interval started in t_stuck_low; toggle the line during it.
        for (int i = 0; i < 20; i++) begin req_n = i[1]; step(1); end
        req_n = 1'b1;
        measure_off(len);
        chk_int("R9 off width unaffected by line toggling", len + 20, REL);
    endtask

    initial begin : watchdog
        while (cycles < 100000) begin @(posedge clk); cycles++; end
        bad++; total++;
        $display("FAIL watchdog expired");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        step(3);
        rst_n = 1'b1;
        step(1);
        t_reset();
        t_idle_high();
        t_short_pulses();
        t_exact_and_release();
        step(5);
        t_mode_gate();
        t_stuck_low();
        t_hold_toggle();
        step(5);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule